// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sits beside a 68000-family processor that runs from an overclocked system clock. It follows the processor's address strobe and classifies each bus cycle from the upper address bits as a RAM, ROM or I/O access. For RAM cycles it drives the DRAM row strobe and a DRAM write enable. For every cycle it returns the active-low data acknowledge after a fixed number of clocks that depends on the region.

Three static strap inputs each lengthen one region's access by exactly one clock. The RAM strap recovers margin when the memory is slower than the clock allows. The ROM strap does the same for the flash. The I/O strap keeps the processor from latching data from the expansion bus before it is valid. The straps are independent, so all eight combinations are legal.

A cycle starts on the first rising clock edge that samples the strobe low after an edge that sampled it high. That edge is called E0 below.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While `rst` is high, `ras_n`, `dtack_n` and `ram_we_n` are all high at the next clock edge.
- R2: On a RAM cycle, `ras_n` goes low at E0 itself. On ROM and I/O cycles it stays high.
- R3: Regions are decoded from `addr_hi` (3 bits by default): values 6–7 are ROM, 4–5 are I/O and 0–3 are RAM. The decode is captured at E0, so later changes of `addr_hi` within the cycle have no effect.
- R4: On a RAM cycle, `dtack_n` goes low at E0+2 when `ram_ws`=0 and at E0+3 when `ram_ws`=1.
- R5: On a ROM cycle, `dtack_n` goes low at E0+3 when `rom_ws`=0 and at E0+4 when `rom_ws`=1.
- R6: On an I/O cycle, `dtack_n` goes low at E0+3 when `io_ws`=0 and at E0+4 when `io_ws`=1.
- R7: Each strap changes only the timing of its own region. Every combination of the three straps is supported.
- R8: Once low, `dtack_n` stays low while `as_n` is low. It returns high on the first edge that samples `as_n` high. `ras_n` and `ram_we_n` return high on that same edge.
- R9: A new cycle needs an edge that sampled `as_n` high, either after reset or after the previous cycle. A strobe that is held low across the release of reset starts no cycle.
- R10: If `as_n` is sampled high before the acknowledge edge, the cycle is abandoned: `dtack_n` never goes low, and `ras_n` returns high on that edge.
- R11: `ram_we_n` goes low together with `ras_n` only on RAM cycles with `rw`=0 at E0 (0 means write). Otherwise it stays high.
- R12: At any edge that samples `as_n` high, `ras_n` and `dtack_n` become high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Processor address strobe, active low |
| rw | input | 1 | Processor read/write, 1 = read |
| addr_hi | input | AW | Upper address bits used for region decode |
| ram_ws | input | 1 | Strap: one extra clock on RAM cycles |
| rom_ws | input | 1 | Strap: one extra clock on ROM cycles |
| io_ws | input | 1 | Strap: one extra clock on I/O cycles |
| ras_n | output | 1 | DRAM row strobe, active low |
| ram_we_n | output | 1 | DRAM write enable, active low |
| dtack_n | output | 1 | Data acknowledge to the processor, active low |

## Verification
A wrong latency load or a wrong region decode shows within the cycle in which it occurs. The acknowledge edge lands one or more clocks away from E0+N, or the row strobe appears on a non-RAM cycle at E0. A sequencer stuck outside idle shows on the first edge that samples the strobe high, because `dtack_n` or `ras_n` fails to return high there. The stale strobe history that R9 depends on shows only after reset with the strobe held low. In that case a spurious row strobe appears one edge after reset is released.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;

  typedef enum logic [1:0] {
    RG_RAM = 2'd0,
    RG_IO  = 2'd1,
    RG_ROM = 2'd2
  } region_t;

  localparam int NREG = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_t;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // base latency for a region slot; unused slot falls back to RAM timing
  function automatic int base_lat(int slot, int ram_l, int io_l, int rom_l);
    case (slot)
      1:       return io_l;
      2:       return rom_l;
      default: return ram_l;
    endcase
  endfunction

endpackage

// File: rtl/bwc_decode.sv
`timescale 1ns/1ps
module bwc_decode
  import bwc_pkg::*;
#(
  parameter int AW        = 3,
  parameter int IO_START  = 4,
  parameter int ROM_START = 6
) (
  input  logic [AW-1:0] addr_hi,
  output region_t       region
);

  localparam logic [AW-1:0] IO_LO  = AW'(IO_START);
  localparam logic [AW-1:0] ROM_LO = AW'(ROM_START);

  always_comb begin
    if (addr_hi >= ROM_LO)      region = RG_ROM;
    else if (addr_hi >= IO_LO)  region = RG_IO;
    else                        region = RG_RAM;
  end

endmodule

// File: rtl/bwc_latency.sv
`timescale 1ns/1ps
module bwc_latency
  import bwc_pkg::*;
#(
  parameter int RAM_LAT = 2,
  parameter int IO_LAT  = 3,
  parameter int ROM_LAT = 3,
  parameter int CW      = 3
) (
  input  region_t          region,
  input  logic [NREG-1:0]  strap,
  output logic [CW-1:0]    lat
);

  logic [CW-1:0] lat_tab [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam int BASE = base_lat(g, RAM_LAT, IO_LAT, ROM_LAT);
    assign lat_tab[g] = CW'(BASE) + CW'(strap[g]);
  end

  assign lat = lat_tab[region];

endmodule

// File: rtl/bwc_sequencer.sv
`timescale 1ns/1ps
module bwc_sequencer
  import bwc_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_n,
  input  logic          rw,
  input  region_t       region,
  input  logic [CW-1:0] lat,
  output logic          ras_n,
  output logic          we_n,
  output logic          dtack_n
);

  seq_state_t    st;
  logic          as_q;
  logic [CW-1:0] cnt;
  logic          start;
  logic          is_ram;

  // a fresh strobe edge: low now, seen high on the previous edge
  assign start  = !as_n && as_q;
  assign is_ram = (region == RG_RAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      as_q    <= 1'b0;
      cnt     <= '0;
      ras_n   <= 1'b1;
      we_n    <= 1'b1;
      dtack_n <= 1'b1;
    end else begin
      as_q <= as_n;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            cnt   <= lat - CW'(1);
            ras_n <= !is_ram;
            we_n  <= !(is_ram && !rw);
            st    <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (as_n) begin
            ras_n <= 1'b1;
            we_n  <= 1'b1;
            st    <= SQ_IDLE;
          end else if (cnt == '0) begin
            dtack_n <= 1'b0;
            st      <= SQ_HOLD;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_HOLD: begin
          if (as_n) begin
            ras_n   <= 1'b1;
            we_n    <= 1'b1;
            dtack_n <= 1'b1;
            st      <= SQ_IDLE;
          end
        end
        default: begin
          ras_n   <= 1'b1;
          we_n    <= 1'b1;
          dtack_n <= 1'b1;
          st      <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_wait_ctrl.sv
`timescale 1ns/1ps
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int AW        = 3,
  parameter int IO_START  = 4,
  parameter int ROM_START = 6,
  parameter int RAM_LAT   = 2,
  parameter int IO_LAT    = 3,
  parameter int ROM_LAT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_n,
  input  logic          rw,
  input  logic [AW-1:0] addr_hi,
  input  logic          ram_ws,
  input  logic          rom_ws,
  input  logic          io_ws,
  output logic          ras_n,
  output logic          ram_we_n,
  output logic          dtack_n
);

  localparam int MAX_LAT = max3(RAM_LAT, IO_LAT, ROM_LAT) + 1;
  localparam int CW      = $clog2(MAX_LAT + 1);

  region_t         region;
  logic [NREG-1:0] strap;
  logic [CW-1:0]   lat;

  // strap slot order follows the region encoding
  assign strap = {1'b0, rom_ws, io_ws, ram_ws};

  bwc_decode #(
    .AW(AW), .IO_START(IO_START), .ROM_START(ROM_START)
  ) u_decode (
    .addr_hi(addr_hi),
    .region (region)
  );

  bwc_latency #(
    .RAM_LAT(RAM_LAT), .IO_LAT(IO_LAT), .ROM_LAT(ROM_LAT), .CW(CW)
  ) u_latency (
    .region(region),
    .strap (strap),
    .lat   (lat)
  );

  bwc_sequencer #(
    .CW(CW)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .as_n   (as_n),
    .rw     (rw),
    .region (region),
    .lat    (lat),
    .ras_n  (ras_n),
    .we_n   (ram_we_n),
    .dtack_n(dtack_n)
  );

endmodule

// File: rtl/bus_wait_ctrl_chk.sv
`timescale 1ns/1ps
module bus_wait_ctrl_chk #(
  parameter int AW        = 3,
  parameter int IO_START  = 4,
  parameter int ROM_START = 6,
  parameter int RAM_LAT   = 2,
  parameter int IO_LAT    = 3,
  parameter int ROM_LAT   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          as_n,
  input logic [AW-1:0] addr_hi,
  input logic          ram_ws,
  input logic          rom_ws,
  input logic          io_ws,
  input logic          ras_n,
  input logic          ram_we_n,
  input logic          dtack_n
);

  logic       ck_prev;
  logic [7:0] ck_cnt;
  logic [7:0] ck_exp;
  logic       ck_ram;
  int         lat_now;

  always_comb begin
    if (int'(addr_hi) >= ROM_START)     lat_now = ROM_LAT + int'(rom_ws);
    else if (int'(addr_hi) >= IO_START) lat_now = IO_LAT + int'(io_ws);
    else                                lat_now = RAM_LAT + int'(ram_ws);
  end

  assign ck_ram = int'(addr_hi) < IO_START;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_prev <= 1'b0;
      ck_cnt  <= '0;
      ck_exp  <= '0;
    end else begin
      ck_prev <= as_n;
      if (!as_n && ck_prev) begin
        ck_cnt <= '0;
        ck_exp <= 8'(lat_now);
      end else if (!as_n && ck_cnt != 8'hff) begin
        ck_cnt <= ck_cnt + 8'd1;
      end
    end
  end

  // R4 R5 R6
  ack_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> ck_cnt == ck_exp);

  // R12
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (ras_n && dtack_n));

  // R2
  ras_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!as_n && $past(as_n) && !$past(rst) && ck_ram) |=> !ras_n);

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && !as_n) |=> !dtack_n);

  // R11
  we_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ras_n);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(as_n, 2) && !$past(as_n)));

endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk #(
  .AW(AW), .IO_START(IO_START), .ROM_START(ROM_START),
  .RAM_LAT(RAM_LAT), .IO_LAT(IO_LAT), .ROM_LAT(ROM_LAT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .as_n    (as_n),
  .addr_hi (addr_hi),
  .ram_ws  (ram_ws),
  .rom_ws  (rom_ws),
  .io_ws   (io_ws),
  .ras_n   (ras_n),
  .ram_we_n(ram_we_n),
  .dtack_n (dtack_n)
);

// File: tb/bus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module bus_wait_ctrl_bench;

  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          as_n = 1'b1;
  logic          rw = 1'b1;
  logic [AW-1:0] addr_hi = '0;
  logic          ram_ws = 1'b0;
  logic          rom_ws = 1'b0;
  logic          io_ws = 1'b0;
  logic          ras_n;
  logic          ram_we_n;
  logic          dtack_n;

  always #2.5 clk = ~clk;

  bus_wait_ctrl u_bus_wait_ctrl (
    .clk(clk), .rst(rst), .as_n(as_n), .rw(rw), .addr_hi(addr_hi),
    .ram_ws(ram_ws), .rom_ws(rom_ws), .io_ws(io_ws),
    .ras_n(ras_n), .ram_we_n(ram_we_n), .dtack_n(dtack_n)
  );

  typedef struct {
    int    lat;
    bit    ras;
    bit    we;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails = 0;
  bit   mon_en = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // regions: 6-7 ROM (3 clocks), 4-5 I/O (3), 0-3 RAM (2); each strap adds 1
  function automatic int exp_lat(logic [AW-1:0] a);
    if (a >= 3'd6) return 3 + int'(rom_ws);
    if (a >= 3'd4) return 3 + int'(io_ws);
    return 2 + int'(ram_ws);
  endfunction

  // driver: strobe low for 'hold' rising edges, address swapped after E0
  task automatic cyc(logic [AW-1:0] a, logic w, int hold, logic [AW-1:0] a2, string req);
    exp_t e;
    int   l;
    @(negedge clk);
    l     = exp_lat(a);
    e.lat = (hold > l) ? l : -1;
    e.ras = (a < 3'd4);
    e.we  = (a < 3'd4) && !w;
    e.req = req;
    sbq.push_back(e);
    addr_hi = a;
    rw      = w;
    as_n    = 1'b0;
    @(negedge clk);
    addr_hi = a2;
    repeat (hold - 1) @(negedge clk);
    as_n = 1'b1;
    rw   = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // monitor: looks 1 ns after each rising edge
  exp_t cur;
  bit   active = 1'b0;
  bit   prev_as = 1'b1;
  int   cnt = 0;
  int   got = -1;

  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      if (!as_n && prev_as) begin
        active = 1'b1;
        cnt    = 0;
        got    = -1;
        if (sbq.size() == 0) begin
          chk(1'b0, "R3", "unexpected cycle", 1, 0);
          cur.lat = -1; cur.ras = 1'b0; cur.we = 1'b0; cur.req = "R3";
        end else begin
          cur = sbq.pop_front();
        end
        chk(ras_n == !cur.ras, {cur.req, " R2"}, "ras_n at E0", int'(ras_n), int'(!cur.ras));
        chk(ram_we_n == !cur.we, {cur.req, " R11"}, "ram_we_n at E0", int'(ram_we_n), int'(!cur.we));
        if (!dtack_n) got = 0;
      end else if (!as_n && active) begin
        cnt++;
        if (!dtack_n && got < 0) got = cnt;
        if (got >= 0 && dtack_n)
          chk(1'b0, {cur.req, " R8"}, "dtack_n released early", int'(dtack_n), 0);
      end else if (as_n && active) begin
        active = 1'b0;
        chk(got == cur.lat, cur.req, "ack latency", got, cur.lat);
        chk(dtack_n && ras_n && ram_we_n, {cur.req, " R8 R10"}, "outputs after strobe high",
            int'({dtack_n, ras_n, ram_we_n}), 7);
      end else if (as_n) begin
        if (!(dtack_n && ras_n)) chk(1'b0, "R12", "idle outputs", int'({dtack_n, ras_n}), 3);
      end
      prev_as = as_n;
    end
  end

  initial begin
    #1000000;
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && dtack_n && ram_we_n, "R1", "reset outputs", int'({ras_n, dtack_n, ram_we_n}), 7);
    // R9: strobe held low across reset release starts nothing
    addr_hi = 3'd1;
    as_n    = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(ras_n && dtack_n, "R9", "held strobe after reset", int'({ras_n, dtack_n}), 3);
    as_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;

    // R4 R5 R6 R7: every strap combination on every region
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      {ram_ws, rom_ws, io_ws} = 3'(s);
      cyc(3'd1, 1'b1, 6, 3'd1, "R4 R7");
      cyc(3'd7, 1'b1, 6, 3'd7, "R5 R7");
      cyc(3'd5, 1'b1, 6, 3'd5, "R6 R7");
    end
    @(negedge clk);
    {ram_ws, rom_ws, io_ws} = 3'b000;

    // R3: decode latched at E0, later address ignored
    cyc(3'd3, 1'b1, 5, 3'd7, "R3");
    cyc(3'd6, 1'b1, 5, 3'd0, "R3");
    cyc(3'd4, 1'b1, 5, 3'd2, "R3");
    cyc(3'd0, 1'b1, 5, 3'd4, "R3");

    // R11: writes
    cyc(3'd2, 1'b0, 5, 3'd2, "R11");
    cyc(3'd6, 1'b0, 5, 3'd6, "R11");
    cyc(3'd5, 1'b0, 5, 3'd5, "R11");

    // R10: early strobe release, and the boundary that just acks
    cyc(3'd7, 1'b1, 2, 3'd7, "R10");
    cyc(3'd0, 1'b1, 2, 3'd0, "R10");
    cyc(3'd0, 1'b1, 1, 3'd0, "R10");
    cyc(3'd0, 1'b1, 3, 3'd0, "R10");
    @(negedge clk);
    ram_ws = 1'b1;
    cyc(3'd2, 1'b1, 3, 3'd2, "R10");
    @(negedge clk);
    ram_ws = 1'b0;

    // R8: long hold
    cyc(3'd1, 1'b1, 12, 3'd1, "R8");
    cyc(3'd5, 1'b1, 10, 3'd5, "R8");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R3", "unconsumed expectations", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule